// File: doc/BRIEF.md
# Nested Priority Interrupt Controller

This block arbitrates eleven interrupt request lines for a small 8-bit processor core. It holds one pending flag per line. Each flag is sampled and updated once per machine cycle, and it is set whether or not its line is enabled. The block masks the flags with a per-line enable and a global enable, then picks a winner using a two-bit priority per line. A new request goes to the core only when its priority is strictly above the deepest level now in service.

The core side uses three signals. A registered call request carries the winning line's index and its fixed vector address. An acknowledge pulse marks the moment the core begins the forced call. A return pulse closes the innermost service level. A four-bit in-service mask, one bit per priority level, holds the nesting state, so four levels can nest. Five byte-wide configuration registers, written and read through a simple port, hold the enable and priority bits.

Top module: `nested_irq_ctrl`

## Requirements
- R1: Each of the eleven lines has its own pending flag. An edge-type line sets its flag at a machine-cycle boundary when it is sampled high after being sampled low at the previous boundary. The flag is set even while the line's enable is 0, and a request appears once the line is enabled later.
- R2: A line can request only when its own enable bit is 1 and the global enable (bit 7 of register 0) is 1. With the global enable at 0, no request is raised.
- R3: Register 0 holds the global enable in bit 7 and the enables of lines 4..0 in bits 4..0. Bits 6 and 5 read back as 0. Register 1 holds the enables of lines 10..5 in bits 5..0. Registers 2, 3 and 4 hold two-bit priorities: line k sits in register 2+k/4 at bits 2*(k%4)+1 : 2*(k%4). Unused bits read 0.
- R4: Among the eligible lines, the one with the numerically highest priority wins (3 is the highest level). Among lines that tie at that priority, the lowest line number wins.
- R5: While any level is in service, only a line whose priority is strictly greater than the highest in-service level may raise a request. Equal or lower priorities wait.
- R6: The call request rises exactly one machine cycle after the boundary that sampled the condition. With a six-machine-cycle forced call, the best-case latency from condition to routine start is 7 machine cycles.
- R7: An acknowledge drops the call request at the next clock. It also sets the in-service bit of the winner's priority and clears the winner's flag when the line is edge-type. A level-type flag instead follows its line at every boundary.
- R8: A return pulse clears the highest set in-service bit. This restores the previous level, so a request that was held back can then be raised.
- R9: The vector address output equals VEC_BASE + VEC_STEP × index, where the index output is the winning line number.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| irq_in | input | 11 | Request condition lines, bit k = line k |
| irq_req | output | 1 | Call request to the core |
| irq_vec | output | 4 | Index of the winning line |
| irq_addr | output | 16 | Vector address of the winning line |
| irq_ack | input | 1 | One-clock pulse: core starts the forced call |
| irq_ret | input | 1 | One-clock pulse: return from interrupt |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 3 | Configuration write register select |
| wr_data | input | 8 | Configuration write data |
| rd_addr | input | 3 | Configuration read register select |
| rd_data | output | 8 | Configuration read data (combinational) |

## Verification
The bench builds the block with three clocks per machine cycle and line 2 set to level type, with every other line edge-type. This exposes the boundary at which each flag updates. It lets the bench line a condition up just before a sampling edge to measure the best-case one-cycle detection, and it exercises both flag kinds, including a level line that raises a new request after its service has returned. The vector base of 3 with a step of 8 makes every index-to-address mapping distinct.

// File: rtl/irqc_pkg.sv
// Package: shared sizes and helpers for the nested interrupt controller.
// Assumes a fixed population of eleven lines and four priority levels.
package irqc_pkg;
    localparam int NSRC   = 11;
    localparam int PRIO_W = 2;
    localparam int NLVL   = 1 << PRIO_W;
    localparam int IDX_W  = $clog2(NSRC);
    localparam int RA_W   = 3;

    typedef logic [PRIO_W-1:0] prio_t;
    typedef logic [IDX_W-1:0]  idx_t;

    // Vector address of a line: base plus step times index.
    function automatic logic [15:0] vec_address(input idx_t idx,
                                                input logic [15:0] base,
                                                input logic [15:0] step);
        return base + 16'(idx) * step;
    endfunction
endpackage

// File: rtl/irqc_cfg_regs.sv
// Configuration registers: global enable, per-line enables, per-line priorities.
// Assumes a single write per clock; reads are combinational.
module irqc_cfg_regs
    import irqc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [RA_W-1:0]              wr_addr,
    input  logic [7:0]                   wr_data,
    input  logic [RA_W-1:0]              rd_addr,
    output logic [7:0]                   rd_data,
    output logic                         glob_en,
    output logic [NSRC-1:0]              src_en,
    output logic [NSRC-1:0][PRIO_W-1:0]  src_prio
);
    localparam int LOW_EN  = 5;              // enables held in register 0
    localparam int SLOTS   = 8 / PRIO_W;     // priorities per register
    localparam int PRIO_RB = 2;              // first priority register

    // Register update on write strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            glob_en  <= 1'b0;
            src_en   <= '0;
            src_prio <= '0;
        end else if (wr_en) begin
            if (wr_addr == RA_W'(0))
                glob_en <= wr_data[7];
            for (int k = 0; k < NSRC; k++) begin
                if (k < LOW_EN && wr_addr == RA_W'(0))
                    src_en[k] <= wr_data[k % 8];
                if (k >= LOW_EN && wr_addr == RA_W'(1))
                    src_en[k] <= wr_data[(k - LOW_EN) % 8];
                if (wr_addr == RA_W'(PRIO_RB + k / SLOTS))
                    src_prio[k] <= wr_data[(k % SLOTS)*PRIO_W +: PRIO_W];
            end
        end
    end

    // Read multiplexer; unused bits return zero.
    always_comb begin
        rd_data = '0;
        if (rd_addr == RA_W'(0))
            rd_data[7] = glob_en;
        for (int k = 0; k < NSRC; k++) begin
            if (k < LOW_EN && rd_addr == RA_W'(0))
                rd_data[k % 8] = src_en[k];
            if (k >= LOW_EN && rd_addr == RA_W'(1))
                rd_data[(k - LOW_EN) % 8] = src_en[k];
            if (rd_addr == RA_W'(PRIO_RB + k / SLOTS))
                rd_data[(k % SLOTS)*PRIO_W +: PRIO_W] = src_prio[k];
        end
    end
endmodule

// File: rtl/irqc_flag_bank.sv
// Pending flags: one per line, edge- or level-type per EDGE_MASK.
// Assumes clr is one-hot or zero; a set at a boundary beats a clear.
module irqc_flag_bank
    import irqc_pkg::*;
#(
    parameter logic [NSRC-1:0] EDGE_MASK = '1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            mc_strobe,
    input  logic [NSRC-1:0] irq_in,
    input  logic [NSRC-1:0] clr,
    output logic [NSRC-1:0] flag
);
    logic [NSRC-1:0] samp_q;

    // Sample the raw lines once per machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         samp_q <= '0;
        else if (mc_strobe) samp_q <= irq_in;
    end

    for (genvar k = 0; k < NSRC; k++) begin : g_src
        if (EDGE_MASK[k]) begin : g_edge
            // Edge flag: set on sampled rise, cleared by acknowledge.
            always_ff @(posedge clk) begin
                if (!rst_n)                                 flag[k] <= 1'b0;
                else if (mc_strobe && irq_in[k] && !samp_q[k]) flag[k] <= 1'b1;
                else if (clr[k])                            flag[k] <= 1'b0;
            end
            assert_ack_clears_edge_R7: assert property (@(posedge clk) disable iff (!rst_n)
                (clr[k] && !mc_strobe) |=> !flag[k]);
        end else begin : g_level
            // Level flag: copy of the line at each boundary.
            always_ff @(posedge clk) begin
                if (!rst_n)         flag[k] <= 1'b0;
                else if (mc_strobe) flag[k] <= irq_in[k];
            end
        end
        assert_flag_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
            (!mc_strobe && !clr[k]) |=> $stable(flag[k]));
    end
endmodule

// File: rtl/irqc_pick.sv
// Winner selection: highest priority above the current level, lowest index on ties.
// Purely combinational; assumes prio fields are stable during the evaluation.
module irqc_pick
    import irqc_pkg::*;
(
    input  logic [NSRC-1:0]             elig,
    input  logic [NSRC-1:0][PRIO_W-1:0] src_prio,
    input  logic                        lvl_valid,
    input  logic [PRIO_W-1:0]           lvl,
    output logic                        win_valid,
    output logic [IDX_W-1:0]            win_idx
);
    logic [PRIO_W-1:0] best_p;

    // Ascending scan with strict compare keeps the lowest index on ties.
    always_comb begin
        win_valid = 1'b0;
        win_idx   = '0;
        best_p    = '0;
        for (int k = 0; k < NSRC; k++) begin
            if (elig[k] && (!lvl_valid || src_prio[k] > lvl) &&
                (!win_valid || src_prio[k] > best_p)) begin
                win_valid = 1'b1;
                win_idx   = IDX_W'(k);
                best_p    = src_prio[k];
            end
        end
    end

    always_comb begin
        if (win_valid)
            assert_pick_eligible_R4: assert (elig[win_idx]);
    end
endmodule

// File: rtl/irqc_svc_stack.sv
// In-service mask: one bit per priority level, push on acknowledge, pop on return.
// Assumes push and pop are never asserted in the same clock.
module irqc_svc_stack
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [PRIO_W-1:0] push_lvl,
    input  logic              pop,
    output logic              lvl_valid,
    output logic [PRIO_W-1:0] lvl
);
    logic [NLVL-1:0] mask_q;
    logic [NLVL-1:0] mask_d;

    // Highest set bit gives the current service level.
    always_comb begin
        lvl = '0;
        for (int l = 0; l < NLVL; l++)
            if (mask_q[l]) lvl = PRIO_W'(l);
    end
    assign lvl_valid = |mask_q;

    // Next mask: clear the top level on pop, set the new level on push.
    always_comb begin
        mask_d = mask_q;
        if (pop && lvl_valid) mask_d[lvl] = 1'b0;
        if (push)             mask_d[push_lvl] = 1'b1;
    end

    // Mask register.
    always_ff @(posedge clk) begin
        if (!rst_n) mask_q <= '0;
        else        mask_q <= mask_d;
    end

    assert_ret_pops_one_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && lvl_valid) |=> $countones(mask_q) == $countones($past(mask_q)) - 1);
    assert_ack_marks_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
        push |=> mask_q[$past(push_lvl)]);
endmodule

// File: rtl/nested_irq_ctrl.sv
// Top: nested priority interrupt controller for an 8-bit core.
// Assumes irq_ack is pulsed only while irq_req is high and irq_ret only
// while a level is in service; ack and ret never share a clock.
module nested_irq_ctrl
    import irqc_pkg::*;
#(
    parameter int              CLK_PER_MC = 3,
    parameter logic [NSRC-1:0] EDGE_MASK  = 11'h7FB,
    parameter logic [15:0]     VEC_BASE   = 16'h0003,
    parameter logic [15:0]     VEC_STEP   = 16'h0008
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NSRC-1:0]   irq_in,
    output logic              irq_req,
    output logic [IDX_W-1:0]  irq_vec,
    output logic [15:0]       irq_addr,
    input  logic              irq_ack,
    input  logic              irq_ret,
    input  logic              wr_en,
    input  logic [RA_W-1:0]   wr_addr,
    input  logic [7:0]        wr_data,
    input  logic [RA_W-1:0]   rd_addr,
    output logic [7:0]        rd_data
);
    localparam int CNT_W = (CLK_PER_MC > 1) ? $clog2(CLK_PER_MC) : 1;

    logic [CNT_W-1:0]            mc_cnt;
    logic                        mc_strobe;
    logic                        glob_en;
    logic [NSRC-1:0]             src_en;
    logic [NSRC-1:0][PRIO_W-1:0] src_prio;
    logic [NSRC-1:0]             flag;
    logic [NSRC-1:0]             clr;
    logic [NSRC-1:0]             elig;
    logic                        lvl_valid;
    logic [PRIO_W-1:0]           lvl;
    logic                        win_valid;
    logic [IDX_W-1:0]            win_idx;
    logic                        take;

    // Machine-cycle divider: strobe on the last clock of each machine cycle.
    always_ff @(posedge clk) begin
        if (!rst_n)         mc_cnt <= '0;
        else if (mc_strobe) mc_cnt <= '0;
        else                mc_cnt <= mc_cnt + 1'b1;
    end
    assign mc_strobe = (mc_cnt == CNT_W'(CLK_PER_MC - 1));

    irqc_cfg_regs u_cfg (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data),
        .glob_en(glob_en), .src_en(src_en), .src_prio(src_prio)
    );

    assign take = irq_ack && irq_req;
    assign clr  = take ? (NSRC'(1) << irq_vec) : '0;

    irqc_flag_bank #(.EDGE_MASK(EDGE_MASK)) u_flags (
        .clk(clk), .rst_n(rst_n), .mc_strobe(mc_strobe),
        .irq_in(irq_in), .clr(clr), .flag(flag)
    );

    assign elig = flag & src_en & {NSRC{glob_en}};

    irqc_pick u_pick (
        .elig(elig), .src_prio(src_prio),
        .lvl_valid(lvl_valid), .lvl(lvl),
        .win_valid(win_valid), .win_idx(win_idx)
    );

    irqc_svc_stack u_stack (
        .clk(clk), .rst_n(rst_n),
        .push(take), .push_lvl(src_prio[irq_vec]),
        .pop(irq_ret), .lvl_valid(lvl_valid), .lvl(lvl)
    );

    // Call request register: re-arbitrated at each boundary, dropped on acknowledge.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_req <= 1'b0;
            irq_vec <= '0;
        end else if (take) begin
            irq_req <= 1'b0;
        end else if (mc_strobe) begin
            irq_req <= win_valid;
            if (win_valid) irq_vec <= win_idx;
        end
    end

    assign irq_addr = vec_address(irq_vec, VEC_BASE, VEC_STEP);

    assert_req_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_req) |-> $past(mc_strobe));
    assert_req_above_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (!lvl_valid || src_prio[irq_vec] > lvl));
    assert_global_mask_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mc_strobe && !glob_en && !take) |=> !irq_req);
    assert_ack_drops_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take |=> !irq_req);
endmodule

// File: tb/test_nested_irq_ctrl.sv
// Directed bench for nested_irq_ctrl: one task per scenario.
module test_nested_irq_ctrl;
    localparam int          CLK_PERIOD = 10;
    localparam int          N          = 3;
    localparam logic [15:0] BASE       = 16'h0003;
    localparam logic [15:0] STEP       = 16'h0008;
    localparam int          CALL_MC    = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [10:0] irq_in = '0;
    logic        irq_req;
    logic [3:0]  irq_vec;
    logic [15:0] irq_addr;
    logic        irq_ack = 1'b0;
    logic        irq_ret = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic [2:0]  rd_addr = '0;
    logic [7:0]  rd_data;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;
    bit done   = 0;

    nested_irq_ctrl #(.CLK_PER_MC(N), .EDGE_MASK(11'h7FB),
                      .VEC_BASE(BASE), .VEC_STEP(STEP)) i_nested_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in),
        .irq_req(irq_req), .irq_vec(irq_vec), .irq_addr(irq_addr),
        .irq_ack(irq_ack), .irq_ret(irq_ret),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) cyc <= rst_n ? cyc + 1 : 0;

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [2:0] a, input int exp, input string tag);
        @(negedge clk); rd_addr = a; #1;
        chk(tag, int'(rd_data), exp);
    endtask

    task automatic cfg_clear();
        for (int a = 0; a < 5; a++) wr(3'(a), 8'h00);
    endtask

    task automatic pulse(input logic [10:0] m);
        @(negedge clk); irq_in = irq_in | m;
        repeat (N) @(negedge clk);
        irq_in = irq_in & ~m;
    endtask

    task automatic ack();
        @(negedge clk); irq_ack = 1'b1;
        @(negedge clk); irq_ack = 1'b0;
    endtask

    task automatic ret();
        @(negedge clk); irq_ret = 1'b1;
        @(negedge clk); irq_ret = 1'b0;
    endtask

    task automatic expect_req(input int v, input string tag);
        int w = 0;
        while (!irq_req && w < 3*N) begin @(negedge clk); w++; end
        chk({tag, " req"}, int'(irq_req), 1);
        chk({tag, " vec"}, int'(irq_vec), v);
        chk({tag, " R9 addr"}, int'(irq_addr), int'(BASE) + int'(STEP) * v);
    endtask

    task automatic expect_none(input string tag);
        int seen = 0;
        for (int i = 0; i < 3*N; i++) begin
            @(negedge clk);
            if (irq_req) seen = 1;
        end
        chk({tag, " no req"}, seen, 0);
    endtask

    task automatic t_reset();
        chk("R7 reset req", int'(irq_req), 0);
        rd_chk(3'd0, 0, "R3 reset reg0");
        rd_chk(3'd2, 0, "R3 reset reg2");
    endtask

    task automatic t_regs();
        wr(3'd0, 8'hFF); rd_chk(3'd0, 8'h9F, "R3 reg0 unused bits");
        wr(3'd1, 8'hFF); rd_chk(3'd1, 8'h3F, "R3 reg1 width");
        wr(3'd3, 8'hB4); rd_chk(3'd3, 8'hB4, "R3 reg3 prio");
        wr(3'd4, 8'hFF); rd_chk(3'd4, 8'h3F, "R3 reg4 width");
        cfg_clear();
    endtask

    task automatic t_latch_disabled();
        wr(3'd0, 8'h80);
        pulse(11'h008);
        expect_none("R2 line disabled");
        wr(3'd0, 8'h88);
        expect_req(3, "R1 latched while disabled");
        ack(); ret();
        expect_none("R7 edge flag cleared");
        cfg_clear();
    endtask

    task automatic t_global();
        wr(3'd0, 8'h08);
        pulse(11'h008);
        expect_none("R2 global off");
        wr(3'd0, 8'h88);
        expect_req(3, "R2 global on");
        ack(); ret();
        cfg_clear();
    endtask

    task automatic t_latency();
        int cnt = 0;
        wr(3'd0, 8'h81);
        repeat (2*N) @(negedge clk);
        while ((cyc + 1) % N != 0) @(negedge clk);
        irq_in[0] = 1'b1;
        while (!irq_req && cnt < 4*N) begin @(posedge clk); cnt++; #1; end
        chk("R6 detect clocks", cnt - 1, N);
        chk("R6 best-case latency MC", (cnt - 1) / N + CALL_MC, 7);
        @(negedge clk); irq_in[0] = 1'b0;
        ack(); ret();
        cfg_clear();
    endtask

    task automatic t_priority();
        wr(3'd2, 8'h04); wr(3'd3, 8'h88);
        wr(3'd0, 8'h82); wr(3'd1, 8'h05);
        pulse(11'h0A2);
        expect_req(5, "R4 high prio low index");
        ack();
        chk("R7 req dropped", int'(irq_req), 0);
        expect_none("R5 equal level waits");
        ret();
        expect_req(7, "R8 equal prio after return");
        ack(); ret();
        expect_req(1, "R4 lower prio last");
        ack(); ret();
        expect_none("R7 all served");
        cfg_clear();
    endtask

    task automatic t_nesting();
        wr(3'd2, 8'h84); wr(3'd3, 8'h33);
        wr(3'd0, 8'h9B); wr(3'd1, 8'h02);
        pulse(11'h001); expect_req(0, "R5 nest lvl0"); ack();
        pulse(11'h002); expect_req(1, "R5 nest lvl1"); ack();
        pulse(11'h008); expect_req(3, "R5 nest lvl2"); ack();
        pulse(11'h010); expect_req(4, "R5 nest lvl3"); ack();
        pulse(11'h040); expect_none("R5 equal top level");
        ret();
        expect_req(6, "R8 restore lvl2");
        ack(); ret();
        ret(); ret();
        pulse(11'h001); expect_none("R5 lvl0 blocks lvl0");
        ret();
        expect_req(0, "R8 restore idle");
        ack(); ret();
        cfg_clear();
    endtask

    task automatic t_level();
        wr(3'd0, 8'h84);
        @(negedge clk); irq_in[2] = 1'b1;
        expect_req(2, "R7 level request");
        ack();
        chk("R7 level ack drop", int'(irq_req), 0);
        ret();
        expect_req(2, "R7 level flag kept");
        ack();
        @(negedge clk); irq_in[2] = 1'b0;
        repeat (2*N) @(negedge clk);
        ret();
        expect_none("R7 level follows input");
        cfg_clear();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_latch_disabled();
        t_global();
        t_latency();
        t_priority();
        t_nesting();
        t_level();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog expired actual=running expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule